// File: doc/BRIEF.md
# Vectorized Streaming Dot Product

This block computes the inner product of two signed integer vectors that arrive as two separate valid/ready streams, each beat carrying `LANES` elements. A job begins with a one-cycle `start` pulse that also carries the element count. While the job runs, a beat is taken only in a cycle where both streams offer data, so the two streams always advance together. Each accepted beat is multiplied lane by lane. The products are summed by a binary adder tree whose depth is log2(`LANES`), and the beat's partial sum is added into a running accumulator.

When every beat of the job has been consumed and has left the pipeline, the accumulated scalar is offered once on a separate result channel. The block keeps `busy` high from the accepted start until that result has been taken. The pipeline can accept one beat every cycle. Both input streams stall when either is empty, and no further input is taken while the result waits for a consumer. The accumulator carries enough guard bits that the largest permitted job cannot overflow.

Top module: `vec_dot_stream`

## Requirements
- R1: After reset `busy`, `res_valid`, `a_ready` and `b_ready` are low. A `start` pulse seen while idle makes `busy` high on the next cycle and clears the accumulator.
- R2: An input beat is consumed only in a cycle where both `a_valid` and `b_valid` are high, and the two streams always handshake in the same cycles.
- R3: The result equals the sum over all elements of the signed product a[i]*b[i]. Lane l of a beat occupies data bits [l*DATA_W +: DATA_W], and element index is beat*LANES + l.
- R4: A job of `n_elems` elements (a multiple of LANES) consumes exactly n_elems/LANES beats. After the last beat `a_ready` and `b_ready` stay low, and exactly one result is offered.
- R5: While idle the block accepts no input beats.
- R6: While `res_valid` is high and `res_ready` is low, `res_data` holds steady, `res_valid` stays high and `busy` stays high.
- R7: `busy` and `res_valid` are low on the cycle after the result handshake.
- R8: A `start` pulse while `busy` is high, including the cycle of the result handshake, is ignored and neither changes the job length nor begins a new job.
- R9: A job with `n_elems` = 0 offers a result of 0.
- R10: Extreme operands (all lanes at the most negative value, or mixed extremes) over the longest test job accumulate without overflow.
- R11: While beats remain and both inputs are valid, a beat is accepted in every cycle (initiation interval 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job request pulse, honoured only while idle |
| n_elems | input | CNT_W | Element count of the job, a multiple of LANES |
| busy | output | 1 | High from accepted start until the result is taken |
| a_valid | input | 1 | First vector beat valid |
| a_ready | output | 1 | First vector beat ready |
| a_data | input | LANES*DATA_W | First vector lanes, signed |
| b_valid | input | 1 | Second vector beat valid |
| b_ready | output | 1 | Second vector beat ready |
| b_data | input | LANES*DATA_W | Second vector lanes, signed |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_data | output | ACC_W | Signed accumulated result |

## Verification
The result handshake and a new start request can fall in the same cycle. There the start must lose, because `busy` is still high while the result is being taken. The bench raises `start` together with `res_ready` on the cycle the result is taken. It expects `busy` and `res_valid` low on the next cycle and no inputs accepted, and a following fresh job must then produce its own correct sum. A second overlap is a start arriving in the middle of a running job, which is judged by the final sum still covering the original element count.

// File: rtl/dot_pkg.sv
package dot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dot_state_e;
endpackage

// File: rtl/dot_lane_mul.sv
module dot_lane_mul #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  localparam int PW    = 2 * DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_fire,
  input  logic [LANES*DATA_W-1:0] a_vec,
  input  logic [LANES*DATA_W-1:0] b_vec,
  output logic                  out_valid,
  output logic [LANES*PW-1:0]   prod_vec
);
  function automatic logic signed [PW-1:0] mul_pair(
    input logic signed [DATA_W-1:0] x,
    input logic signed [DATA_W-1:0] y
  );
    return PW'(x) * PW'(y);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prod_vec[l*PW +: PW] <= '0;
      end else if (in_fire) begin
        prod_vec[l*PW +: PW] <= mul_pair(a_vec[l*DATA_W +: DATA_W],
                                         b_vec[l*DATA_W +: DATA_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_fire;
  end

  // R2: a product stage is loaded only by a consumed beat
  a_r2_prod_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);
endmodule

// File: rtl/dot_adder_tree.sv
module dot_adder_tree #(
  parameter int LANES = 4,
  parameter int IN_W  = 32,
  localparam int LG   = (LANES > 1) ? $clog2(LANES) : 0,
  localparam int OUT_W = IN_W + LG,
  localparam int NODES = 2 * LANES - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*IN_W-1:0]   in_vec,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sum
);
  function automatic logic signed [OUT_W-1:0] widen(input logic signed [IN_W-1:0] v);
    return OUT_W'(v);
  endfunction

  logic signed [OUT_W-1:0] node [NODES];

  for (genvar l = 0; l < LANES; l++) begin : g_leaf
    assign node[LANES-1+l] = widen(in_vec[l*IN_W +: IN_W]);
  end

  for (genvar n = 0; n < LANES - 1; n++) begin : g_node
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sum <= node[0];
    end
  end

  // R3: partial sums only appear one cycle after products arrive
  a_r3_tree_timing: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/dot_ctrl.sv
module dot_ctrl #(
  parameter int LANES = 4,
  parameter int CNT_W = 12,
  localparam int LG   = (LANES > 1) ? $clog2(LANES) : 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_elems,
  input  logic             a_valid,
  input  logic             b_valid,
  input  logic             pipe_busy,
  input  logic             res_ready,
  output logic             a_ready,
  output logic             b_ready,
  output logic             beat_fire,
  output logic             job_take,
  output logic             res_valid,
  output logic             busy
);
  import dot_pkg::*;

  dot_state_e       state;
  logic [CNT_W-1:0] beats_left;
  logic             want_beat;
  logic             drain_done;
  logic             res_take;

  function automatic logic [CNT_W-1:0] beats_of(input logic [CNT_W-1:0] n);
    return n >> LG;
  endfunction

  assign want_beat  = (state == ST_RUN) && (beats_left != '0);
  assign a_ready    = want_beat && b_valid;
  assign b_ready    = want_beat && a_valid;
  assign beat_fire  = want_beat && a_valid && b_valid;
  assign job_take   = (state == ST_IDLE) && start;
  assign drain_done = (state == ST_RUN) && (beats_left == '0) && !pipe_busy;
  assign res_valid  = (state == ST_DONE);
  assign res_take   = res_valid && res_ready;
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      beats_left <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state      <= ST_RUN;
          beats_left <= beats_of(n_elems);
        end
        ST_RUN: begin
          if (beat_fire) beats_left <= beats_left - 1'b1;
          if (drain_done) state <= ST_DONE;
        end
        ST_DONE: if (res_take) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: both streams handshake together
  a_r2_paired: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) == (b_valid && b_ready));
  // R5: no beat taken while idle
  a_r5_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(a_ready || b_ready));
  // R4: no beat taken once the result is pending
  a_r4_no_late_beat: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(a_ready || b_ready));
  // R6: pending result stays offered
  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && busy));
  // R7: busy drops after the result is taken
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    res_take |=> !busy);
  // R8: start during a running job leaves the count alone
  a_r8_ignore_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && start && !beat_fire) |=> (beats_left == $past(beats_left)));
  // R8: start during the result cycle does not open a job
  a_r8_ignore_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && start) |=> (state != ST_RUN));
  // R1: accepted start raises busy
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    job_take |=> busy);
endmodule

// File: rtl/vec_dot_stream.sv
module vec_dot_stream #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12,
  localparam int PW    = 2 * DATA_W,
  localparam int LG    = (LANES > 1) ? $clog2(LANES) : 0,
  localparam int TW    = PW + LG,
  localparam int ACC_W = PW + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CNT_W-1:0]        n_elems,
  output logic                    busy,
  input  logic                    a_valid,
  output logic                    a_ready,
  input  logic [LANES*DATA_W-1:0] a_data,
  input  logic                    b_valid,
  output logic                    b_ready,
  input  logic [LANES*DATA_W-1:0] b_data,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [ACC_W-1:0]        res_data
);
  logic                 beat_fire;
  logic                 job_take;
  logic                 prod_valid;
  logic [LANES*PW-1:0]  prod_vec;
  logic                 part_valid;
  logic signed [TW-1:0] part_sum;
  logic signed [ACC_W-1:0] acc;
  logic                 pipe_busy;

  assign pipe_busy = prod_valid || part_valid;

  dot_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .n_elems   (n_elems),
    .a_valid   (a_valid),
    .b_valid   (b_valid),
    .pipe_busy (pipe_busy),
    .res_ready (res_ready),
    .a_ready   (a_ready),
    .b_ready   (b_ready),
    .beat_fire (beat_fire),
    .job_take  (job_take),
    .res_valid (res_valid),
    .busy      (busy)
  );

  dot_lane_mul #(.LANES(LANES), .DATA_W(DATA_W)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (beat_fire),
    .a_vec     (a_data),
    .b_vec     (b_data),
    .out_valid (prod_valid),
    .prod_vec  (prod_vec)
  );

  dot_adder_tree #(.LANES(LANES), .IN_W(PW)) u_tree (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (prod_valid),
    .in_vec    (prod_vec),
    .out_valid (part_valid),
    .out_sum   (part_sum)
  );

  function automatic logic signed [ACC_W-1:0] acc_add(
    input logic signed [ACC_W-1:0] base,
    input logic signed [TW-1:0]    part
  );
    return base + ACC_W'(part);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)          acc <= '0;
    else if (job_take)   acc <= '0;
    else if (part_valid) acc <= acc_add(acc, part_sum);
  end

  assign res_data = acc;

  // R6: offered result does not move while waiting
  a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> $stable(res_data));
  // R4: pipeline is empty whenever the result is offered
  a_r4_drained: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !pipe_busy);
endmodule

// File: tb/test_vec_dot_stream.sv
module test_vec_dot_stream;
  localparam int LANES = 4;
  localparam int DW    = 16;
  localparam int CW    = 12;
  localparam int AW    = 2 * DW + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] n_elems = '0;
  logic busy;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic a_ready, b_ready;
  logic [LANES*DW-1:0] a_data = '0, b_data = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [AW-1:0] res_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic signed [DW-1:0] av [512];
  logic signed [DW-1:0] bv [512];

  always #2.5 clk = ~clk;

  vec_dot_stream #(.LANES(LANES), .DATA_W(DW), .CNT_W(CW)) i_vec_dot_stream (
    .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems), .busy(busy),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [LANES*DW-1:0] pack_a(input int k);
    logic [LANES*DW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*DW +: DW] = av[k*LANES+l];
    return v;
  endfunction

  function automatic logic [LANES*DW-1:0] pack_b(input int k);
    logic [LANES*DW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*DW +: DW] = bv[k*LANES+l];
    return v;
  endfunction

  function automatic longint ref_dot(input int nb);
    longint s = 0;
    for (int i = 0; i < nb * LANES; i++) s += longint'(av[i]) * longint'(bv[i]);
    return s;
  endfunction

  task automatic fill_pattern(input int seed);
    int unsigned x = seed;
    for (int i = 0; i < 512; i++) begin
      x = x * 1103515245 + 12345;
      av[i] = DW'(x >> 9);
      x = x * 1103515245 + 12345;
      bv[i] = DW'(x >> 11);
    end
  endtask

  // One job: stall selects input bubbles, mid_start pulses start mid-run,
  // hold delays res_ready, hs_start raises start with the result handshake.
  task automatic run_job(input int nb, input bit stall, input bit mid_start,
                         input int hold, input bit hs_start, input string req);
    int k = 0;
    int c = 0;
    bit af, bf;
    longint exp_v, got;
    @(negedge clk);
    n_elems = CW'(nb * LANES);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", busy, 1);
    while (k < nb && c < 5000) begin
      a_valid = !(stall && (c % 3 == 1));
      b_valid = !(stall && (c % 4 == 2));
      a_data = pack_a(k);
      b_data = pack_b(k);
      start = mid_start && (c == 1);
      n_elems = mid_start ? CW'(LANES) : CW'(nb * LANES);
      #1;
      af = a_valid && a_ready;
      bf = b_valid && b_ready;
      if (af != bf) chk(1'b0, "R2", af, bf);
      if ((!a_valid || !b_valid) && af) chk(1'b0, "R2", af, 0);
      if (a_valid && b_valid && !a_ready) chk(1'b0, "R11", a_ready, 1);
      @(negedge clk);
      if (af) k++;
      c++;
    end
    start = 1'b0;
    chk(k == nb, "R11", k, nb);
    a_valid = 1'b1;
    b_valid = 1'b1;
    for (int w = 0; w < 50 && !res_valid; w++) begin
      #1;
      if (a_ready || b_ready) chk(1'b0, "R4", a_ready, 0);
      @(negedge clk);
    end
    a_valid = 1'b0;
    b_valid = 1'b0;
    chk(res_valid == 1'b1, "R4", res_valid, 1);
    exp_v = ref_dot(nb);
    got = longint'($signed(res_data));
    chk(got == exp_v, req, got, exp_v);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      got = longint'($signed(res_data));
      chk(res_valid && busy && got == exp_v, "R6", got, exp_v);
    end
    res_ready = 1'b1;
    start = hs_start;
    n_elems = CW'(2 * LANES);
    @(negedge clk);
    res_ready = 1'b0;
    start = 1'b0;
    chk(!res_valid, "R7", res_valid, 0);
    chk(!busy, hs_start ? "R8" : "R7", busy, 0);
    if (hs_start) begin
      a_valid = 1'b1;
      b_valid = 1'b1;
      #1;
      chk(!a_ready && !b_ready, "R8", a_ready, 0);
      @(negedge clk);
      a_valid = 1'b0;
      b_valid = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk(!busy, "R1", busy, 0);
    chk(!res_valid, "R1", res_valid, 0);
    chk(!a_ready && !b_ready, "R1", a_ready, 0);
  endtask

  task automatic t_idle_ignore;
    @(negedge clk);
    a_valid = 1'b1;
    b_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!a_ready && !b_ready && !busy, "R5", a_ready, 0);
      @(negedge clk);
    end
    a_valid = 1'b0;
    b_valid = 1'b0;
  endtask

  task automatic t_extremes;
    for (int i = 0; i < 512; i++) begin
      av[i] = 16'sh8000;
      bv[i] = 16'sh8000;
    end
    run_job(100, 1'b0, 1'b0, 0, 1'b0, "R10");
    for (int i = 0; i < 512; i++) begin
      av[i] = 16'sh8000;
      bv[i] = (i % 2 == 0) ? 16'sh7fff : 16'sh8000;
    end
    run_job(64, 1'b1, 1'b0, 0, 1'b0, "R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    fill_pattern(7);
    run_job(3, 1'b0, 1'b0, 0, 1'b0, "R3");
    fill_pattern(99);
    run_job(8, 1'b1, 1'b0, 3, 1'b0, "R3");
    run_job(1, 1'b0, 1'b0, 1, 1'b0, "R3");
    run_job(0, 1'b0, 1'b0, 0, 1'b0, "R9");
    fill_pattern(1234);
    run_job(6, 1'b0, 1'b1, 0, 1'b1, "R8");
    fill_pattern(5);
    run_job(5, 1'b1, 1'b0, 2, 1'b0, "R3");
    t_extremes();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule